// File: doc/BRIEF.md
# Radix-4 Booth Sequential Signed Multiplier

This block multiplies two 32-bit two's-complement operands and produces their full 64-bit signed product. It consumes two multiplier bits per clock. Each step recodes a pair of multiplier bits, together with the bit consumed just before them, into a signed digit from -2 to +2. It adds that multiple of the multiplicand into a high accumulator and then shifts the accumulator and low register pair right by two bits. A full product takes 16 steps.

A one-cycle start pulse captures both operands. The accumulator is cleared, the multiplier goes into the low half and the multiplicand into its own register. The product port always shows the accumulator and low halves side by side, so the partial state can be seen during the run. A one-cycle done pulse marks the product as final. The product then holds until the next start.

A start pulse that arrives while a product is still being formed abandons that product and begins the new one.

Top module: `booth4_mul`

## Requirements
- R1: While reset is held, and after it is released with no start, done_o is 0 and product_o is all zeros.
- R2: On the clock edge that samples start_i high, the accumulator is cleared and the low half is loaded with mplier_i. In the following cycle, product_o equals {32'h0, mplier_i}.
- R3: When done_o is 1, product_o equals the signed 64-bit product of the captured mcand_i and mplier_i, for all operand values including -2^31.
- R4: done_o is 1 for exactly one cycle, and that cycle is the one after the 16th clock edge following the start edge; it is 0 in all earlier cycles of the run.
- R5: After done_o, product_o keeps its value in every cycle until start_i is sampled high again.
- R6: A start_i sampled while a product is in progress discards that product. The new product completes 16 edges after the new start, with no done_o in between.
- R7: The digit for the triplet {lo[1], lo[0], prev} is chosen as follows: 000 and 111 give 0; 001 and 010 give +1x; 011 gives +2x; 100 gives -2x; 101 and 110 give -1x. prev is 0 for the first step. After the first step, product_o equals the 66-bit value {digit*mcand sign-extended to 34 bits, mplier} shifted right arithmetically by 2, keeping its low 64 bits.
- R8: Each step after the first uses as prev the lo[1] bit consumed by the step before it. As a result, runs of ones and alternating bit patterns in the multiplier give the correct product.
- R9: The multiplicand is extended to 34 bits before doubling, so a +2x or -2x digit applied to -2^31 does not overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that captures the operands and begins a product |
| mcand_i | input | 32 | Signed multiplicand |
| mplier_i | input | 32 | Signed multiplier |
| done_o | output | 1 | One-cycle pulse: product_o is final |
| product_o | output | 64 | Accumulator low 32 bits concatenated with the low register |

## Verification
The product port exposes the accumulator and low register directly. A wrong load is therefore visible in the cycle right after start, and a wrong recoded digit or sign extension is visible one edge later in the partial value. A wrong saved previous bit only corrupts the digit of the next step, so it is caught by final products of multipliers with runs of ones and alternating bits. A step counter that is off by any amount moves the done pulse away from the 16th edge, and the bench checks it at that exact cycle.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

    // One recoded radix-4 digit: magnitude 0, 1 or 2 with a sign.
    typedef struct packed {
        logic en;   // digit is nonzero
        logic neg;  // subtract instead of add
        logic dbl;  // magnitude two
    } booth_digit_t;

endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder
    import booth4_pkg::*;
(
    input  logic [2:0]   triplet_i,  // {b1, b0, prev}
    output booth_digit_t digit_o
);

    always_comb begin
        digit_o = '0;
        unique case (triplet_i)
            3'b000, 3'b111: digit_o = '{en: 1'b0, neg: 1'b0, dbl: 1'b0};
            3'b001, 3'b010: digit_o = '{en: 1'b1, neg: 1'b0, dbl: 1'b0};
            3'b011:         digit_o = '{en: 1'b1, neg: 1'b0, dbl: 1'b1};
            3'b100:         digit_o = '{en: 1'b1, neg: 1'b1, dbl: 1'b1};
            3'b101, 3'b110: digit_o = '{en: 1'b1, neg: 1'b1, dbl: 1'b0};
            default:        digit_o = '0;
        endcase
        // R7
        dbl_needs_en_chk: assert (!digit_o.dbl || digit_o.en);
    end

endmodule

// File: rtl/booth4_addsub.sv
module booth4_addsub
    import booth4_pkg::*;
#(
    parameter int EXT_W = 34
) (
    input  logic [EXT_W-1:0] acc_i,
    input  logic [EXT_W-1:0] mcand_ext_i,
    input  booth_digit_t     digit_i,
    output logic [EXT_W-1:0] sum_o
);

    logic [EXT_W-1:0] mag;

    always_comb begin
        mag = digit_i.dbl ? {mcand_ext_i[EXT_W-2:0], 1'b0} : mcand_ext_i;
        if (!digit_i.en) begin
            mag = '0;
        end
        sum_o = digit_i.neg ? (acc_i - mag) : (acc_i + mag);
    end

endmodule

// File: rtl/booth4_mul.sv
module booth4_mul
    import booth4_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           done_o,
    output logic [2*W-1:0] product_o
);

    localparam int EXT_W = W + 2;
    localparam int STEPS = W / 2;
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

    typedef struct packed {
        logic [EXT_W-1:0] hi;
        logic [W-1:0]     lo;
        logic [W-1:0]     mcand;
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } mul_state_t;

    mul_state_t          st_d, st_q;
    booth_digit_t        digit;
    logic [EXT_W-1:0]    mcand_ext;
    logic [EXT_W-1:0]    sum;
    logic signed [EXT_W-1:0] sum_s;

    assign mcand_ext = {{2{st_q.mcand[W-1]}}, st_q.mcand};

    booth4_recoder u_recoder (
        .triplet_i ({st_q.lo[1:0], st_q.prev}),
        .digit_o   (digit)
    );

    booth4_addsub #(.EXT_W(EXT_W)) u_addsub (
        .acc_i       (st_q.hi),
        .mcand_ext_i (mcand_ext),
        .digit_i     (digit),
        .sum_o       (sum)
    );

    assign sum_s = sum;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.hi    = '0;
            st_d.lo    = mplier_i;
            st_d.mcand = mcand_i;
            st_d.prev  = 1'b0;
            st_d.cnt   = '0;
            st_d.busy  = 1'b1;
        end else if (st_q.busy) begin
            st_d.hi   = sum_s >>> 2;
            st_d.lo   = {sum[1:0], st_q.lo[W-1:2]};
            st_d.prev = st_q.lo[1];
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o    = st_q.done;
    assign product_o = {st_q.hi[W-1:0], st_q.lo};

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (product_o == {{W{1'b0}}, $past(mplier_i)}));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !st_q.busy);

    // R4
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt < CNT_W'(STEPS)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start_i) |=> $stable(product_o));

    // R8
    prev_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !start_i && !done_o) |=> (st_q.prev == $past(st_q.lo[1]) || done_o));

endmodule

// File: tb/booth4_mul_bench.sv
`timescale 1ns/1ps
module booth4_mul_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] mcand_i = '0;
    logic [31:0] mplier_i = '0;
    logic        done_o;
    logic [63:0] product_o;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    booth4_mul u_booth4_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .done_o    (done_o),
        .product_o (product_o)
    );

    function automatic logic [63:0] ref_mul(logic [31:0] a, logic [31:0] b);
        logic signed [63:0] ea, eb;
        ea = {{32{a[31]}}, a};
        eb = {{32{b[31]}}, b};
        return ea * eb;
    endfunction

    function automatic logic [63:0] ref_step1(logic [31:0] a, logic [31:0] b);
        logic signed [33:0] sa, acc;
        logic signed [65:0] full;
        sa = {{2{a[31]}}, a};
        case (b[1:0])
            2'b00:   acc = '0;
            2'b01:   acc = sa;
            2'b10:   acc = -(sa <<< 1);
            default: acc = -sa;
        endcase
        full = {acc, b};
        full = full >>> 2;
        return full[63:0];
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue_start(logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        start_i  = 1'b1;
        mcand_i  = a;
        mplier_i = b;
        @(negedge clk);
        start_i  = 1'b0;
        mcand_i  = $urandom;
        mplier_i = $urandom;
    endtask

    // Waits out a run that started on the last edge and checks it.
    task automatic finish_run(logic [31:0] a, logic [31:0] b);
        logic [63:0] exp, held;
        int early;
        exp = ref_mul(a, b);
        early = 0;
        for (int k = 1; k < 16; k++) begin
            @(negedge clk);
            if (done_o) early++;
        end
        check(early == 0, "R4 done early", 64'(early), 64'd0);
        @(negedge clk);
        check(done_o == 1'b1, "R4 done at step 16", {63'd0, done_o}, 64'd1);
        check(product_o == exp, "R3 product", product_o, exp);
        held = product_o;
        @(negedge clk);
        check(done_o == 1'b0, "R4 done one cycle", {63'd0, done_o}, 64'd0);
        @(negedge clk);
        @(negedge clk);
        check(product_o == held, "R5 product held", product_o, held);
    endtask

    task automatic run_mul(logic [31:0] a, logic [31:0] b, string tag);
        issue_start(a, b);
        check(product_o == {32'h0, b}, "R2 load", product_o, {32'h0, b});
        finish_run(a, b);
        if (fails > 0 && tag.len() == 0) $display("note");
    endtask

    task automatic first_step(logic [31:0] a, logic [31:0] b);
        logic [63:0] exp;
        issue_start(a, b);
        @(negedge clk);
        exp = ref_step1(a, b);
        check(product_o == exp, "R7 first step digit", product_o, exp);
        for (int k = 2; k <= 16; k++) @(negedge clk);
        check(product_o == ref_mul(a, b), "R7 product after digit", product_o, ref_mul(a, b));
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h5EED_B004);
        repeat (3) @(negedge clk);
        // R1 under reset
        check(done_o == 1'b0 && product_o == 64'd0, "R1 reset", product_o, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done_o == 1'b0 && product_o == 64'd0, "R1 after reset", product_o, 64'd0);

        // Directed cases
        run_mul(32'd0, 32'd0, "R3");
        run_mul(32'd1, 32'd1, "R3");
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
        run_mul(32'hFFFF_FFF9, 32'd3, "R3");
        // R9 extreme operands
        run_mul(32'h8000_0000, 32'h8000_0000, "R9");
        run_mul(32'h8000_0000, 32'h7FFF_FFFF, "R9");
        run_mul(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9");
        run_mul(32'h8000_0000, 32'hFFFF_FFFF, "R9");
        run_mul(32'h8000_0000, 32'h6666_6666, "R9");
        // R8 runs of ones and alternating bits
        run_mul(32'h1234_5678, 32'h5555_5555, "R8");
        run_mul(32'hDEAD_BEEF, 32'hAAAA_AAAA, "R8");
        run_mul(32'h0BAD_F00D, 32'h0FF0_0FF0, "R8");
        run_mul(32'hCAFE_0001, 32'h7FFF_FFFF, "R8");

        // R7 each low pair with prev 0, including the -2x digit
        first_step(32'h1357_9BDF, 32'h0000_0000);
        first_step(32'h1357_9BDF, 32'h0000_0001);
        first_step(32'h8000_0000, 32'h0000_0002);
        first_step(32'hF000_000F, 32'h0000_0003);
        first_step(32'h7FFF_FFFF, 32'hAAAA_AAAE);

        // R6 restart during a run
        issue_start(32'h0000_1111, 32'h0000_2222);
        begin
            int early;
            early = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (done_o) early++;
            end
            check(early == 0, "R6 no done before restart", 64'(early), 64'd0);
        end
        issue_start(32'hFEDC_BA98, 32'h0123_4567);
        check(product_o == {32'h0, 32'h0123_4567}, "R6 reload", product_o, {32'h0, 32'h0123_4567});
        finish_run(32'hFEDC_BA98, 32'h0123_4567);

        // Constrained random: half full range, half small magnitudes
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (i % 2 == 1) begin
                a = {{20{a[31]}}, a[11:0]};
                b = {{20{b[31]}}, b[11:0]};
            end
            run_mul(a, b, "R3");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule